// File: doc/BRIEF.md
# Self-Aligning Interleaved Carrier Cell

One instance of this block sits in each switching cell of a chain of parallel converter legs. Each cell hears only from the cell in front of it. The upstream cell passes three values forward: its position number, the active-cell total and its carrier phase. From these the cell forms its own position, the running total, a base phase step of one turn divided by the total, and its own phase, which is the upstream phase plus that step. It then forwards all of these to the next cell. No central controller takes part, and the carriers settle to an exact even spread instead of drifting towards one.

The position chain is open. A cell that sees position zero knows it is first. It takes the total from a loop-back line wired to the tail of the chain, which carries the last cell's outgoing position. Every other cell copies the total from its upstream neighbour.

Each cell also runs a triangular carrier offset by its phase. It compares the carrier with the duty reference to drive a complementary pair of gate outputs. The master cell sources the duty reference and the carrier sync pulse, and every cell forwards both down the chain. A cell that is disabled becomes transparent: all chain values pass straight through it and its gates are held off. Chain registers change only on a sample strobe.

Top module: `carrier_align_cell`

## Requirements
- R1: On a sample strobe with the cell enabled, `idxOut` becomes `idxIn + 1` (modulo 8) from the next clock onward.
- R2: On a strobe, a cell whose `idxIn` is 0 latches its count from `tailIdxIn`. Any other cell latches it from `cntIn`. The latched count appears on `cntOut`.
- R3: The base phase step is floor(65536 / N), taken modulo 65536, where N is the count held before the strobe. The value 65536 stands for one full turn. N = 0 gives a step of 0.
- R4: On a strobe, `phaseOut` becomes `phaseIn` plus the base step, modulo 65536.
- R5: Reset clears position, count and phase to 0. Without a strobe, the chain outputs of an enabled cell do not change.
- R6: While `cellEn` is low, the cell is transparent. `idxOut`, `cntOut`, `phaseOut`, `dutyOut` and `syncOut` equal `idxIn`, `cntIn`, `phaseIn`, `dutyIn` and `syncIn`, and both gates are 0. The cell's internal state is held unchanged and reappears when `cellEn` returns high.
- R7: In an enabled master cell (`isMaster` high), `dutyOut` = `dutyLocal` and `syncOut` = `syncLocal`, and `dutyIn` and `syncIn` are ignored. In a non-master cell, the forwarded inputs are used.
- R8: A ramp register is cleared by the effective sync (`syncLocal` for a master cell, `syncIn` otherwise) and otherwise gains RAMP_STEP on every clock. With s = ramp + phase (modulo 65536), the carrier is `{~s[14:0],0}` when s[15] = 1 and `{s[14:0],0}` when s[15] = 0. `gateHi` is 1 exactly when the forwarded duty is greater than the carrier.
- R9: While the cell is enabled, `gateLo` is the complement of `gateHi`.
- R10: In a chain whose first cell sees position 0, with its tail loop-back connected, the k-th enabled cell settles to position k, count N and phase k·step(N). This happens within 2N+1 strobes from any prior state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sampleStb | input | 1 | Time-step strobe for the chain registers |
| cellEn | input | 1 | Cell active; low makes the cell transparent |
| isMaster | input | 1 | Cell sources duty and sync |
| idxIn | input | IDX_W | Upstream position |
| cntIn | input | IDX_W | Upstream active-cell total |
| tailIdxIn | input | IDX_W | Loop-back of the chain tail position |
| phaseIn | input | PH_W | Upstream carrier phase |
| dutyIn | input | PH_W | Forwarded duty reference |
| syncIn | input | 1 | Forwarded carrier sync |
| dutyLocal | input | PH_W | Duty reference sourced by a master |
| syncLocal | input | 1 | Sync pulse sourced by a master |
| idxOut | output | IDX_W | Own position |
| cntOut | output | IDX_W | Own active-cell total |
| phaseOut | output | PH_W | Own carrier phase |
| dutyOut | output | PH_W | Duty reference sent downstream |
| syncOut | output | 1 | Sync sent downstream |
| gateHi | output | 1 | High-side gate |
| gateLo | output | 1 | Low-side gate |

## Verification
The single cell is swept over every incoming position, including the wrap from 7 to 0. Every count from 0 to 7 is tried with an upstream phase near the top of the range, which separates a correct modulo sum and step table from a truncated or off-by-one result. The gate comparison is followed across full carrier periods for duties of zero, full scale and two mid values. A four-cell chain is then stepped through all sixteen enable masks without a reset in between. This shows whether bypass, first-cell detection and count loop-back together give an exact spread from stale state.

// File: rtl/carrier_align_pkg.sv
package carrier_align_pkg;

  typedef struct packed {
    logic latchChain;  // update position, count and phase this cycle
    logic bypass;      // cell transparent, gates off
    logic useLocal;    // duty and sync come from the local master inputs
    logic rampClear;   // restart the carrier ramp
  } cellCtl_t;

endpackage

// File: rtl/carrier_align_ctrl.sv
module carrier_align_ctrl
  import carrier_align_pkg::*;
(
  input  logic     sampleStb,
  input  logic     cellEn,
  input  logic     isMaster,
  input  logic     syncIn,
  input  logic     syncLocal,
  output cellCtl_t ctl
);

  always_comb begin
    ctl.latchChain = sampleStb & cellEn;
    ctl.bypass     = ~cellEn;
    ctl.useLocal   = isMaster;
    ctl.rampClear  = isMaster ? syncLocal : syncIn;
  end

endmodule

// File: rtl/carrier_align_dp.sv
module carrier_align_dp
  import carrier_align_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int PH_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cellCtl_t         ctl,
  input  logic [IDX_W-1:0] idxIn,
  input  logic [IDX_W-1:0] cntIn,
  input  logic [IDX_W-1:0] tailIdxIn,
  input  logic [PH_W-1:0]  phaseIn,
  input  logic [PH_W-1:0]  dutyIn,
  input  logic             syncIn,
  input  logic [PH_W-1:0]  dutyLocal,
  input  logic             syncLocal,
  output logic [IDX_W-1:0] idxOut,
  output logic [IDX_W-1:0] cntOut,
  output logic [PH_W-1:0]  phaseOut,
  output logic [PH_W-1:0]  dutyOut,
  output logic             syncOut,
  output logic [PH_W-1:0]  phaseHeld,
  output logic [PH_W-1:0]  dutyEff
);

  localparam int NUM_CNT = 1 << IDX_W;
  localparam logic [PH_W:0] FULL_TURN = {1'b1, {PH_W{1'b0}}};

  // Step table: one turn divided by the count; count 0 maps to no step.
  logic [PH_W-1:0] stepLut [NUM_CNT];

  generate
    for (genvar n = 0; n < NUM_CNT; n++) begin : g_step
      if (n == 0) begin : g_zero
        assign stepLut[n] = '0;
      end else begin : g_div
        localparam logic [PH_W:0] QUOT = FULL_TURN / (PH_W+1)'(n);
        assign stepLut[n] = QUOT[PH_W-1:0];
      end
    end
  endgenerate

  logic [IDX_W-1:0] idxReg, cntReg;
  logic [PH_W-1:0]  phaseReg;
  logic [IDX_W-1:0] cntNext;
  logic [PH_W-1:0]  baseStep;
  logic             isFirst;

  assign isFirst  = (idxIn == '0);
  assign cntNext  = isFirst ? tailIdxIn : cntIn;
  assign baseStep = stepLut[cntReg];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idxReg   <= '0;
      cntReg   <= '0;
      phaseReg <= '0;
    end else if (ctl.latchChain) begin
      idxReg   <= idxIn + IDX_W'(1);
      cntReg   <= cntNext;
      phaseReg <= phaseIn + baseStep;
    end
  end

  always_comb begin
    dutyEff = ctl.useLocal ? dutyLocal : dutyIn;
    if (ctl.bypass) begin
      idxOut   = idxIn;
      cntOut   = cntIn;
      phaseOut = phaseIn;
      dutyOut  = dutyIn;
      syncOut  = syncIn;
    end else begin
      idxOut   = idxReg;
      cntOut   = cntReg;
      phaseOut = phaseReg;
      dutyOut  = dutyEff;
      syncOut  = ctl.useLocal ? syncLocal : syncIn;
    end
  end

  assign phaseHeld = phaseReg;

endmodule

// File: rtl/carrier_align_tri.sv
module carrier_align_tri
  import carrier_align_pkg::*;
#(
  parameter int PH_W      = 16,
  parameter int RAMP_STEP = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cellCtl_t        ctl,
  input  logic [PH_W-1:0] phase,
  input  logic [PH_W-1:0] duty,
  output logic            gateHi,
  output logic            gateLo
);

  localparam logic [PH_W-1:0] STEP = PH_W'(RAMP_STEP);

  logic [PH_W-1:0] rampReg;
  logic [PH_W-1:0] shifted;
  logic [PH_W-1:0] carrier;
  logic            cmpHi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             rampReg <= '0;
    else if (ctl.rampClear) rampReg <= '0;
    else                    rampReg <= rampReg + STEP;
  end

  // Fold the offset sawtooth into a triangle: rising half, then falling half.
  assign shifted = rampReg + phase;
  assign carrier = shifted[PH_W-1] ? {~shifted[PH_W-2:0], 1'b0}
                                   : { shifted[PH_W-2:0], 1'b0};
  assign cmpHi   = (duty > carrier);

  assign gateHi = ~ctl.bypass & cmpHi;
  assign gateLo = ~ctl.bypass & ~cmpHi;

endmodule

// File: rtl/carrier_align_cell.sv
module carrier_align_cell
  import carrier_align_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int PH_W      = 16,
  parameter int RAMP_STEP = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sampleStb,
  input  logic             cellEn,
  input  logic             isMaster,
  input  logic [IDX_W-1:0] idxIn,
  input  logic [IDX_W-1:0] cntIn,
  input  logic [IDX_W-1:0] tailIdxIn,
  input  logic [PH_W-1:0]  phaseIn,
  input  logic [PH_W-1:0]  dutyIn,
  input  logic             syncIn,
  input  logic [PH_W-1:0]  dutyLocal,
  input  logic             syncLocal,
  output logic [IDX_W-1:0] idxOut,
  output logic [IDX_W-1:0] cntOut,
  output logic [PH_W-1:0]  phaseOut,
  output logic [PH_W-1:0]  dutyOut,
  output logic             syncOut,
  output logic             gateHi,
  output logic             gateLo
);

  cellCtl_t        ctl;
  logic [PH_W-1:0] phaseHeld;
  logic [PH_W-1:0] dutyEff;

  carrier_align_ctrl ctrl_i (
    .sampleStb (sampleStb),
    .cellEn    (cellEn),
    .isMaster  (isMaster),
    .syncIn    (syncIn),
    .syncLocal (syncLocal),
    .ctl       (ctl)
  );

  carrier_align_dp #(.IDX_W(IDX_W), .PH_W(PH_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .idxIn     (idxIn),
    .cntIn     (cntIn),
    .tailIdxIn (tailIdxIn),
    .phaseIn   (phaseIn),
    .dutyIn    (dutyIn),
    .syncIn    (syncIn),
    .dutyLocal (dutyLocal),
    .syncLocal (syncLocal),
    .idxOut    (idxOut),
    .cntOut    (cntOut),
    .phaseOut  (phaseOut),
    .dutyOut   (dutyOut),
    .syncOut   (syncOut),
    .phaseHeld (phaseHeld),
    .dutyEff   (dutyEff)
  );

  carrier_align_tri #(.PH_W(PH_W), .RAMP_STEP(RAMP_STEP)) tri_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .phase  (phaseHeld),
    .duty   (dutyEff),
    .gateHi (gateHi),
    .gateLo (gateLo)
  );

endmodule

// File: rtl/carrier_align_cell_chk.sv
module carrier_align_cell_chk #(
  parameter int IDX_W = 3,
  parameter int PH_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sampleStb,
  input logic             cellEn,
  input logic             isMaster,
  input logic [IDX_W-1:0] idxIn,
  input logic [IDX_W-1:0] cntIn,
  input logic [IDX_W-1:0] tailIdxIn,
  input logic [PH_W-1:0]  phaseIn,
  input logic [PH_W-1:0]  dutyIn,
  input logic             syncIn,
  input logic [PH_W-1:0]  dutyLocal,
  input logic             syncLocal,
  input logic [IDX_W-1:0] idxOut,
  input logic [IDX_W-1:0] cntOut,
  input logic [PH_W-1:0]  phaseOut,
  input logic [PH_W-1:0]  dutyOut,
  input logic             syncOut,
  input logic             gateHi,
  input logic             gateLo
);

  function automatic logic [PH_W-1:0] stepOf(input logic [IDX_W-1:0] n);
    logic [PH_W:0] q;
    if (n == '0) return '0;
    q = {1'b1, {PH_W{1'b0}}} / (PH_W+1)'(n);
    return q[PH_W-1:0];
  endfunction

  p_idx_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && cellEn) |=> (!cellEn || idxOut == $past(idxIn + IDX_W'(1))));

  p_cnt_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && cellEn) |=>
      (!cellEn || cntOut == $past((idxIn == '0) ? tailIdxIn : cntIn)));

  p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sampleStb && cellEn) |=>
      (!cellEn || phaseOut == $past(phaseIn + stepOf(cntOut))));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sampleStb && cellEn) |=>
      (!cellEn || ($stable(idxOut) && $stable(cntOut) && $stable(phaseOut))));

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cellEn |-> (idxOut == idxIn && cntOut == cntIn && phaseOut == phaseIn &&
                 dutyOut == dutyIn && syncOut == syncIn && !gateHi && !gateLo));

  p_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cellEn && isMaster) |-> (dutyOut == dutyLocal && syncOut == syncLocal));

  p_gate_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cellEn |-> $countones({gateHi, gateLo}) == 1);

endmodule

bind carrier_align_cell carrier_align_cell_chk #(.IDX_W(IDX_W), .PH_W(PH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb), .cellEn(cellEn),
  .isMaster(isMaster), .idxIn(idxIn), .cntIn(cntIn), .tailIdxIn(tailIdxIn),
  .phaseIn(phaseIn), .dutyIn(dutyIn), .syncIn(syncIn), .dutyLocal(dutyLocal),
  .syncLocal(syncLocal), .idxOut(idxOut), .cntOut(cntOut), .phaseOut(phaseOut),
  .dutyOut(dutyOut), .syncOut(syncOut), .gateHi(gateHi), .gateLo(gateLo)
);

// File: tb/carrier_align_cell_tb_top.sv
`timescale 1ns/1ps
module carrier_align_cell_tb_top;

  localparam int IDX_W = 3;
  localparam int PH_W  = 16;
  localparam int RSTEP = 256;
  localparam int NCH   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic             sampleStb = 0, cellEn = 1, isMaster = 0;
  logic [IDX_W-1:0] idxIn = 0, cntIn = 0, tailIdxIn = 0;
  logic [PH_W-1:0]  phaseIn = 0, dutyIn = 0, dutyLocal = 0;
  logic             syncIn = 0, syncLocal = 0;
  logic [IDX_W-1:0] idxOut, cntOut;
  logic [PH_W-1:0]  phaseOut, dutyOut;
  logic             syncOut, gateHi, gateLo;

  carrier_align_cell #(.IDX_W(IDX_W), .PH_W(PH_W), .RAMP_STEP(RSTEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .sampleStb(sampleStb), .cellEn(cellEn),
    .isMaster(isMaster), .idxIn(idxIn), .cntIn(cntIn), .tailIdxIn(tailIdxIn),
    .phaseIn(phaseIn), .dutyIn(dutyIn), .syncIn(syncIn), .dutyLocal(dutyLocal),
    .syncLocal(syncLocal), .idxOut(idxOut), .cntOut(cntOut), .phaseOut(phaseOut),
    .dutyOut(dutyOut), .syncOut(syncOut), .gateHi(gateHi), .gateLo(gateLo)
  );

  // Four-cell chain for the alignment sweep.
  logic             chainStb = 0;
  logic [NCH-1:0]   chainEn = '1;
  logic [IDX_W-1:0] cIdx [NCH+1];
  logic [IDX_W-1:0] cCnt [NCH+1];
  logic [PH_W-1:0]  cPh  [NCH+1];
  logic [PH_W-1:0]  cDuty[NCH+1];
  logic             cSync[NCH+1];
  logic [NCH-1:0]   cHi, cLo;

  assign cIdx[0] = '0;
  assign cCnt[0] = '0;
  assign cPh[0]  = '0;
  assign cDuty[0] = '0;
  assign cSync[0] = 1'b0;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_chain
      carrier_align_cell #(.IDX_W(IDX_W), .PH_W(PH_W), .RAMP_STEP(RSTEP)) cell_i (
        .clk(clk), .rst_n(rst_n), .sampleStb(chainStb), .cellEn(chainEn[c]),
        .isMaster(c == 0), .idxIn(cIdx[c]), .cntIn(cCnt[c]), .tailIdxIn(cIdx[NCH]),
        .phaseIn(cPh[c]), .dutyIn(cDuty[c]), .syncIn(cSync[c]),
        .dutyLocal(16'h8000), .syncLocal(1'b0),
        .idxOut(cIdx[c+1]), .cntOut(cCnt[c+1]), .phaseOut(cPh[c+1]),
        .dutyOut(cDuty[c+1]), .syncOut(cSync[c+1]), .gateHi(cHi[c]), .gateLo(cLo[c])
      );
    end
  endgenerate

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [PH_W-1:0] stepOf(input int n);
    if (n == 0) return '0;
    return PH_W'(65536 / n);
  endfunction

  function automatic logic triHi(input logic [PH_W-1:0] duty, input int ramp,
                                 input logic [PH_W-1:0] ph);
    int s, t;
    s = (ramp + ph) & 16'hFFFF;
    t = (s >= 32768) ? (((~s) & 16'h7FFF) << 1) : ((s & 16'h7FFF) << 1);
    return (int'(duty) > t);
  endfunction

  task automatic strobe();
    @(negedge clk) sampleStb = 1;
    @(negedge clk) sampleStb = 0;
  endtask

  task automatic chainStrobe();
    @(negedge clk) chainStb = 1;
    @(negedge clk) chainStb = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [PH_W-1:0] heldPh;
    repeat (3) @(negedge clk);
    // R5: reset state
    chk("R5 reset idx", idxOut, 0);
    chk("R5 reset cnt", cntOut, 0);
    chk("R5 reset phase", phaseOut, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: every incoming position, including wrap 7 -> 0
    for (int i = 0; i < 8; i++) begin
      idxIn = IDX_W'(i);
      strobe();
      chk("R1 idx next", idxOut, (i + 1) % 8);
    end

    // R2: first cell takes loop-back, others copy upstream
    idxIn = 0; tailIdxIn = 5; cntIn = 2;
    strobe();
    chk("R2 first cell count", cntOut, 5);
    idxIn = 3; tailIdxIn = 1; cntIn = 6;
    strobe();
    chk("R2 follower count", cntOut, 6);

    // R3/R4: step for each count, phase wraps modulo one turn
    for (int n = 0; n < 8; n++) begin
      idxIn = 2; cntIn = IDX_W'(n); phaseIn = 16'hF000;
      strobe();
      strobe();
      chk("R3 R4 phase step", phaseOut, 32'(16'(16'hF000 + stepOf(n))));
    end

    // R5: no strobe, no change
    idxIn = 6; cntIn = 1; phaseIn = 16'h1234; tailIdxIn = 4;
    repeat (4) @(negedge clk);
    chk("R5 hold idx", idxOut, 3);
    chk("R5 hold cnt", cntOut, 7);
    chk("R5 hold phase", phaseOut, 32'(16'(16'hF000 + stepOf(7))));

    // R6: bypass passthrough, gates off, state retained
    cellEn = 0; dutyIn = 16'hFFFF; dutyLocal = 16'h0;
    for (int p = 0; p < 4; p++) begin
      idxIn = IDX_W'(p * 3); cntIn = IDX_W'(p + 2); phaseIn = PH_W'(p * 16'h3111);
      syncIn = p[0];
      strobe();
      chk("R6 bypass idx", idxOut, idxIn);
      chk("R6 bypass cnt", cntOut, cntIn);
      chk("R6 bypass phase", phaseOut, phaseIn);
      chk("R6 bypass duty", dutyOut, dutyIn);
      chk("R6 bypass sync", syncOut, syncIn);
      chk("R6 bypass gates", {gateHi, gateLo}, 0);
    end
    syncIn = 0;
    cellEn = 1;
    @(negedge clk);
    chk("R6 state kept idx", idxOut, 3);
    chk("R6 state kept cnt", cntOut, 7);

    // R7: master sources duty and sync
    dutyIn = 16'h1111; dutyLocal = 16'h2222; syncIn = 1; syncLocal = 0;
    isMaster = 1;
    @(negedge clk);
    chk("R7 master duty", dutyOut, 16'h2222);
    chk("R7 master sync", syncOut, 0);
    isMaster = 0;
    @(negedge clk);
    chk("R7 follower duty", dutyOut, 16'h1111);
    chk("R7 follower sync", syncOut, 1);
    syncIn = 0;

    // R8/R9: gate compare across carrier periods
    isMaster = 1;
    idxIn = 2; cntIn = 0; phaseIn = 16'h3000;
    strobe();
    strobe();
    heldPh = 16'h3000;
    foreach (dutyIn[i]) begin end
    for (int d = 0; d < 4; d++) begin
      logic [PH_W-1:0] dv;
      int ramp;
      dv = (d == 0) ? 16'h0000 : (d == 1) ? 16'h4000 : (d == 2) ? 16'h8000 : 16'hFFFF;
      dutyLocal = dv;
      @(negedge clk) syncLocal = 1;
      @(negedge clk) syncLocal = 0;
      ramp = 0;
      for (int t = 0; t < 300; t++) begin
        chk("R8 gate high", gateHi, triHi(dv, ramp, heldPh));
        chk("R9 gate low", gateLo, !triHi(dv, ramp, heldPh));
        @(negedge clk);
        ramp = (ramp + RSTEP) & 16'hFFFF;
      end
    end
    isMaster = 0;

    // R10: chain alignment over all enable masks, no reset between
    for (int m = 0; m < 16; m++) begin
      int nAct, k;
      chainEn = NCH'(m);
      nAct = $countones(NCH'(m));
      for (int s = 0; s < 2 * NCH + 1; s++) chainStrobe();
      chk("R10 chain tail", cIdx[NCH], nAct);
      k = 0;
      for (int c = 0; c < NCH; c++) begin
        if (m[c]) begin
          k++;
          chk("R10 chain idx", cIdx[c+1], k);
          chk("R10 chain cnt", cCnt[c+1], nAct);
          chk("R10 chain phase", cPh[c+1], 32'(16'(k * stepOf(nAct))));
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule